// File: doc/BRIEF.md
# Synchronous Burst Read Port

This block is the device-side read path of a synchronous memory that hands 16-bit words to a host in bursts. The host drives a start address and pulses the active-low address strobe while chip select is active. The block then counts a programmable number of clocks before the first word appears on the data outputs. From then on, each clock edge presents the next word of the burst, either in plain ascending order or wrapping inside an aligned block of 4, 8, 16 or 32 words.

A ready pin rises one clock before the first word is presented, so the host can wait on it instead of counting cycles itself. The data pins are released (high impedance, shown by a low drive-enable) whenever chip select or output enable is inactive. Deselecting the chip ends the burst. The 32-word wrap is refused for starts in the spare region at the top of the address map. Such a request runs as a plain ascending burst instead, and an error flag is latched. The storage behind the port is a behavioural array whose contents are a fixed function of the address.

The data path is a plain pin interface driven by the host's strobes and has no valid/ready back-pressure. Output enable acts as the only pause control: while it is inactive, the burst position is held.

Top module: `sync_burst_reader`

## Requirements
- R1: After reset, rdy, dq_oe and spare_err are low, the initial latency is 4 clocks and the burst order is linear.
- R2: A rising edge with ce_n low and adv_n low captures addr as the burst start. It cancels any burst in progress, and rdy is low after that edge.
- R3: The first word is presented on dq, with dq_oe high, after the L-th rising edge following the capture edge. L is the latency written through cfg_lat when cfg_we is high, and its legal range is 3 to 7.
- R4: A cfg_lat value below 3 is stored as 3, and a value above 7 is stored as 7.
- R5: rdy goes high after edge L-1, one clock ahead of the first word, and stays high while the burst runs.
- R6: With cfg_mode 0 (linear), each rising edge during the burst advances the address by one, modulo 2^16. For example, FFFF is followed by 0000.
- R7: cfg_mode values 1, 2, 3 and 4 select wrap lengths 4, 8, 16 and 32. The address advances inside the block aligned to that length and returns to the block base. For example, with length 8, a start at 2 gives 2,3,4,5,6,7,0,1. cfg_mode values 5 to 7 behave as linear.
- R8: The word presented for address a is ((a * 0x9E37) mod 2^16) XOR 0x5A5A.
- R9: dq_oe is low whenever ce_n or oe_n is high, and dq then reads 0.
- R10: While oe_n is high during a burst, the position is held. When oe_n returns low, the same word is presented again before advancing.
- R11: A rising edge with ce_n high ends the burst. rdy and dq_oe then stay low until the next capture.
- R12: A capture with cfg_mode 4 at an address of 0xFF00 or above runs as a linear burst and sets spare_err. spare_err stays set until reset. The shorter wrap lengths stay available in that region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the latency and order settings |
| cfg_lat | input | 4 | Requested initial latency in clocks |
| cfg_mode | input | 3 | Burst order: 0 linear, 1 to 4 wrap 4/8/16/32 |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| adv_n | input | 1 | Address strobe, active low |
| addr | input | 16 | Burst start address |
| rdy | output | 1 | High one clock before the first word and through the burst |
| dq_oe | output | 1 | Data pin drive enable; low means high impedance |
| dq | output | 16 | Burst data word |
| spare_err | output | 1 | Sticky flag: 32-word wrap refused in the spare region |

## Verification
A latency counter or stored latency that is off by one moves the rise of rdy and the first dq_oe by a clock. This shows up within seven clocks of the capture edge, because each waiting cycle is checked. A wrong burst position shows as a wrong data word on the very next edge. Failures at the wrap point or in the hold-while-disabled path surface on the first edge where the sequence differs from the model. A spare-region decision that is wrong shows in the first word past the aligned 32-word block, and also in spare_err right after the capture.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef enum logic [2:0] {
    BM_LINEAR = 3'd0,
    BM_WRAP4  = 3'd1,
    BM_WRAP8  = 3'd2,
    BM_WRAP16 = 3'd3,
    BM_WRAP32 = 3'd4
  } burst_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_BURST = 2'd2
  } seq_state_e;

endpackage

// File: rtl/burst_cfg.sv
module burst_cfg
  import burst_pkg::*;
#(
  parameter int LAT_IN_W = 4,
  parameter int LAT_MIN  = 3,
  parameter int LAT_MAX  = 7,
  parameter int LAT_RST  = 4,
  localparam int LAT_W   = $clog2(LAT_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [LAT_IN_W-1:0] lat_in,
  input  logic [2:0]          mode_in,
  output logic [LAT_W-1:0]    lat,
  output burst_mode_e         mode
);

  logic [LAT_W-1:0] lat_clamped;
  burst_mode_e      mode_norm;

  always_comb begin
    if (int'(lat_in) < LAT_MIN)      lat_clamped = LAT_W'(LAT_MIN);
    else if (int'(lat_in) > LAT_MAX) lat_clamped = LAT_W'(LAT_MAX);
    else                             lat_clamped = LAT_W'(lat_in);
  end

  always_comb begin
    if (mode_in > 3'd4) mode_norm = BM_LINEAR;
    else                mode_norm = burst_mode_e'(mode_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat  <= LAT_W'(LAT_RST);
      mode <= BM_LINEAR;
    end else if (we) begin
      lat  <= lat_clamped;
      mode <= mode_norm;
    end
  end

endmodule

// File: rtl/burst_addr_step.sv
module burst_addr_step
  import burst_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] cur,
  input  burst_mode_e       mode,
  output logic [ADDR_W-1:0] nxt
);

  logic [ADDR_W-1:0] mask;
  logic [ADDR_W-1:0] inc;

  always_comb begin
    case (mode)
      BM_WRAP4:  mask = ADDR_W'(3);
      BM_WRAP8:  mask = ADDR_W'(7);
      BM_WRAP16: mask = ADDR_W'(15);
      BM_WRAP32: mask = ADDR_W'(31);
      default:   mask = '0;
    endcase
  end

  assign inc = cur + ADDR_W'(1);

  always_comb begin
    if (mode == BM_LINEAR) nxt = inc;
    else                   nxt = (cur & ~mask) | (inc & mask);
  end

endmodule

// File: rtl/burst_mem.sv
module burst_mem #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter logic [31:0] MULT = 32'h0000_9E37,
  parameter logic [31:0] SALT = 32'h0000_5A5A
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] word
);

  logic [31:0] prod;

  assign prod = 32'(addr) * MULT;
  assign word = prod[DATA_W-1:0] ^ SALT[DATA_W-1:0];

endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LAT_W      = 3,
  parameter int SPARE_BASE = 'hFF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              adv_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LAT_W-1:0]  cfg_lat,
  input  burst_mode_e       cfg_mode,
  input  logic [ADDR_W-1:0] nxt_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output burst_mode_e       mode_eff,
  output logic              in_burst,
  output logic              rdy,
  output logic              spare_err
);

  seq_state_e       state;
  logic [LAT_W-1:0] cnt;
  logic [LAT_W-1:0] lat_q;
  logic             capture;
  logic             fallback;

  assign capture  = !ce_n && !adv_n;
  assign fallback = (cfg_mode == BM_WRAP32) && (addr >= ADDR_W'(SPARE_BASE));
  assign in_burst = (state == ST_BURST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      lat_q     <= '0;
      cur_addr  <= '0;
      mode_eff  <= BM_LINEAR;
      rdy       <= 1'b0;
      spare_err <= 1'b0;
    end else if (capture) begin
      state    <= ST_WAIT;
      cnt      <= LAT_W'(1);
      lat_q    <= cfg_lat;
      cur_addr <= addr;
      mode_eff <= fallback ? BM_LINEAR : cfg_mode;
      rdy      <= 1'b0;
      if (fallback) spare_err <= 1'b1;
    end else if (ce_n) begin
      state <= ST_IDLE;
      rdy   <= 1'b0;
    end else begin
      case (state)
        ST_WAIT: begin
          cnt <= cnt + LAT_W'(1);
          if (cnt == lat_q - LAT_W'(1)) rdy <= 1'b1;
          if (cnt == lat_q) state <= ST_BURST;
        end
        ST_BURST: begin
          if (!oe_n) cur_addr <= nxt_addr;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sync_burst_reader.sv
module sync_burst_reader
  import burst_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int LAT_IN_W   = 4,
  parameter int LAT_MIN    = 3,
  parameter int LAT_MAX    = 7,
  parameter int LAT_RST    = 4,
  parameter int SPARE_BASE = 'hFF00
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [LAT_IN_W-1:0] cfg_lat,
  input  logic [2:0]          cfg_mode,
  input  logic                ce_n,
  input  logic                oe_n,
  input  logic                adv_n,
  input  logic [ADDR_W-1:0]   addr,
  output logic                rdy,
  output logic                dq_oe,
  output logic [DATA_W-1:0]   dq,
  output logic                spare_err
);

  localparam int LAT_W = $clog2(LAT_MAX + 1);

  logic [LAT_W-1:0]  lat_cfg;
  burst_mode_e       mode_cfg;
  burst_mode_e       mode_eff;
  logic [ADDR_W-1:0] cur_addr;
  logic [ADDR_W-1:0] nxt_addr;
  logic [DATA_W-1:0] mem_word;
  logic              in_burst;

  burst_cfg #(
    .LAT_IN_W (LAT_IN_W),
    .LAT_MIN  (LAT_MIN),
    .LAT_MAX  (LAT_MAX),
    .LAT_RST  (LAT_RST)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .lat_in  (cfg_lat),
    .mode_in (cfg_mode),
    .lat     (lat_cfg),
    .mode    (mode_cfg)
  );

  burst_seq #(
    .ADDR_W     (ADDR_W),
    .LAT_W      (LAT_W),
    .SPARE_BASE (SPARE_BASE)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .adv_n     (adv_n),
    .addr      (addr),
    .cfg_lat   (lat_cfg),
    .cfg_mode  (mode_cfg),
    .nxt_addr  (nxt_addr),
    .cur_addr  (cur_addr),
    .mode_eff  (mode_eff),
    .in_burst  (in_burst),
    .rdy       (rdy),
    .spare_err (spare_err)
  );

  burst_addr_step #(
    .ADDR_W (ADDR_W)
  ) u_step (
    .cur  (cur_addr),
    .mode (mode_eff),
    .nxt  (nxt_addr)
  );

  burst_mem #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_mem (
    .addr (cur_addr),
    .word (mem_word)
  );

  assign dq_oe = in_burst && !ce_n && !oe_n;
  assign dq    = dq_oe ? mem_word : '0;

endmodule

// File: rtl/burst_reader_chk.sv
module burst_reader_chk
  import burst_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int LAT_W   = 3,
  parameter int LAT_MIN = 3,
  parameter int LAT_MAX = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              adv_n,
  input logic              rdy,
  input logic              dq_oe,
  input logic              spare_err,
  input logic              in_burst,
  input logic [ADDR_W-1:0] cur_addr,
  input burst_mode_e       mode_eff,
  input logic [LAT_W-1:0]  lat_cfg
);

  logic [ADDR_W-1:0] mask;
  logic [ADDR_W-1:0] base;

  always_comb begin
    case (mode_eff)
      BM_WRAP4:  mask = ADDR_W'(3);
      BM_WRAP8:  mask = ADDR_W'(7);
      BM_WRAP16: mask = ADDR_W'(15);
      BM_WRAP32: mask = ADDR_W'(31);
      default:   mask = '0;
    endcase
  end
  assign base = cur_addr & ~mask;

  // R2: a capture cancels the burst and drops ready
  a_r2_capture_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !adv_n) |=> (!rdy && !in_burst));

  // R4: stored latency stays in the legal range
  a_r4_latency_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(lat_cfg) >= LAT_MIN) && (int'(lat_cfg) <= LAT_MAX));

  // R5: ready leads the burst by one clock
  a_r5_ready_leads_data: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rdy) && !ce_n && adv_n) |=> in_burst);

  // R6: linear order advances by one
  a_r6_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (in_burst && !ce_n && !oe_n && adv_n && mode_eff == BM_LINEAR)
      |=> (cur_addr == $past(cur_addr) + ADDR_W'(1)));

  // R7: wrap order stays inside its aligned block
  a_r7_wrap_stays_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (in_burst && !ce_n && !oe_n && adv_n && mode_eff != BM_LINEAR)
      |=> (base == $past(base) && cur_addr != $past(cur_addr)));

  // R9: no drive while either enable is inactive
  a_r9_release_pins: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n) |-> !dq_oe);

  // R10: position held while output enable is inactive
  a_r10_hold_on_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (in_burst && !ce_n && oe_n && adv_n) |=> $stable(cur_addr));

  // R11: deselect ends the burst
  a_r11_deselect_ends: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> (!rdy && !in_burst));

  // R12: the spare-region flag is sticky
  a_r12_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    spare_err |=> spare_err);

endmodule

bind sync_burst_reader burst_reader_chk #(
  .ADDR_W  (ADDR_W),
  .LAT_W   (LAT_W),
  .LAT_MIN (LAT_MIN),
  .LAT_MAX (LAT_MAX)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce_n      (ce_n),
  .oe_n      (oe_n),
  .adv_n     (adv_n),
  .rdy       (rdy),
  .dq_oe     (dq_oe),
  .spare_err (spare_err),
  .in_burst  (in_burst),
  .cur_addr  (cur_addr),
  .mode_eff  (mode_eff),
  .lat_cfg   (lat_cfg)
);

// File: tb/tb_sync_burst_reader.sv
module tb_sync_burst_reader;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_lat = 4'd0;
  logic [2:0]  cfg_mode = 3'd0;
  logic        ce_n = 1'b1;
  logic        oe_n = 1'b1;
  logic        adv_n = 1'b1;
  logic [15:0] addr = 16'h0;
  logic        rdy;
  logic        dq_oe;
  logic [15:0] dq;
  logic        spare_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  sync_burst_reader dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_lat   (cfg_lat),
    .cfg_mode  (cfg_mode),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .adv_n     (adv_n),
    .addr      (addr),
    .rdy       (rdy),
    .dq_oe     (dq_oe),
    .dq        (dq),
    .spare_err (spare_err)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [15:0] model_word(input logic [15:0] a);
    logic [31:0] p;
    p = 32'(a) * 32'h9E37;
    return p[15:0] ^ 16'h5A5A;
  endfunction

  function automatic logic [15:0] model_next(input logic [15:0] a, input int mode,
                                             input bit fb);
    logic [15:0] len;
    if (mode >= 1 && mode <= 4 && !fb) begin
      len = 16'(1) << (mode + 1);
      return (a & ~(len - 16'd1)) | ((a + 16'd1) & (len - 16'd1));
    end
    return a + 16'd1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic cfg_write(input int lat, input int mode);
    cfg_we = 1'b1; cfg_lat = 4'(lat); cfg_mode = 3'(mode);
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic capture(input logic [15:0] a);
    ce_n = 1'b0; oe_n = 1'b0; adv_n = 1'b0; addr = a;
    tick();
    adv_n = 1'b1;
  endtask

  task automatic release_bus();
    ce_n = 1'b1; oe_n = 1'b1;
    tick();
  endtask

  // Called right after the capture edge.
  task automatic expect_burst(input string req, input logic [15:0] start, input int mode,
                              input int lat, input int n, input bit fb);
    logic [15:0] a;
    a = start;
    chk({req, " rdy low after capture (R2)"}, 32'(rdy), 0);
    for (int k = 1; k <= lat; k++) begin
      tick();
      if (k < lat) begin
        chk({req, " rdy timing (R5)"}, 32'(rdy), 32'(k == lat - 1));
        chk({req, " no drive during latency (R3)"}, 32'(dq_oe), 0);
      end else begin
        chk({req, " first word drive (R3)"}, 32'(dq_oe), 1);
        chk({req, " first word data (R8)"}, 32'(dq), 32'(model_word(a)));
        chk({req, " rdy held (R5)"}, 32'(rdy), 1);
      end
    end
    for (int i = 1; i < n; i++) begin
      tick();
      a = model_next(a, mode, fb);
      chk({req, " burst word"}, 32'(dq), 32'(model_word(a)));
    end
  endtask

  task automatic t_reset();
    chk("R1 rdy", 32'(rdy), 0);
    chk("R1 dq_oe", 32'(dq_oe), 0);
    chk("R1 spare_err", 32'(spare_err), 0);
    capture(16'h0001);
    expect_burst("R1 default latency 4 linear R6", 16'h0001, 0, 4, 6, 1'b0);
    release_bus();
  endtask

  task automatic t_latency();
    cfg_write(3, 0);
    capture(16'h1234);
    expect_burst("R3 latency 3", 16'h1234, 0, 3, 4, 1'b0);
    release_bus();
    cfg_write(7, 0);
    capture(16'h0777);
    expect_burst("R3 latency 7", 16'h0777, 0, 7, 4, 1'b0);
    release_bus();
  endtask

  task automatic t_clamp();
    cfg_write(1, 0);
    capture(16'h0050);
    expect_burst("R4 clamp low", 16'h0050, 0, 3, 2, 1'b0);
    release_bus();
    cfg_write(14, 0);
    capture(16'h0060);
    expect_burst("R4 clamp high", 16'h0060, 0, 7, 2, 1'b0);
    release_bus();
  endtask

  task automatic t_wrap();
    cfg_write(4, 1);
    capture(16'h0102);
    expect_burst("R7 wrap4", 16'h0102, 1, 4, 10, 1'b0);
    release_bus();
    cfg_write(5, 2);
    capture(16'h0002);
    expect_burst("R7 wrap8", 16'h0002, 2, 5, 12, 1'b0);
    release_bus();
    cfg_write(3, 3);
    capture(16'h034E);
    expect_burst("R7 wrap16", 16'h034E, 3, 3, 20, 1'b0);
    release_bus();
    cfg_write(4, 4);
    capture(16'h201E);
    expect_burst("R7 wrap32", 16'h201E, 4, 4, 40, 1'b0);
    release_bus();
  endtask

  task automatic t_rollover_reserved();
    cfg_write(4, 0);
    capture(16'hFFFD);
    expect_burst("R6 rollover", 16'hFFFD, 0, 4, 5, 1'b0);
    release_bus();
    cfg_write(4, 6);
    capture(16'h002E);
    expect_burst("R7 reserved mode linear", 16'h002E, 0, 4, 6, 1'b0);
    release_bus();
  endtask

  task automatic t_oe_pause();
    cfg_write(4, 0);
    capture(16'h0040);
    expect_burst("R10 pre-pause", 16'h0040, 0, 4, 2, 1'b0);
    oe_n = 1'b1;
    #1;
    chk("R9 oe high releases", 32'(dq_oe), 0);
    chk("R9 dq zero when released", 32'(dq), 0);
    tick();
    tick();
    chk("R9 still released", 32'(dq_oe), 0);
    oe_n = 1'b0;
    #1;
    chk("R10 resume drive", 32'(dq_oe), 1);
    chk("R10 same word resumes", 32'(dq), 32'(model_word(16'h0041)));
    tick();
    chk("R10 advance after resume", 32'(dq), 32'(model_word(16'h0042)));
    release_bus();
  endtask

  task automatic t_ce_end();
    cfg_write(3, 0);
    capture(16'h0500);
    expect_burst("R11 pre-deselect", 16'h0500, 0, 3, 3, 1'b0);
    ce_n = 1'b1;
    #1;
    chk("R9 ce high releases", 32'(dq_oe), 0);
    tick();
    ce_n = 1'b0; oe_n = 1'b0;
    #1;
    chk("R11 rdy low after deselect", 32'(rdy), 0);
    chk("R11 no drive after deselect", 32'(dq_oe), 0);
    tick(); tick(); tick(); tick();
    chk("R11 stays idle rdy", 32'(rdy), 0);
    chk("R11 stays idle drive", 32'(dq_oe), 0);
    release_bus();
  endtask

  task automatic t_restart();
    cfg_write(4, 2);
    capture(16'h0100);
    expect_burst("R2 first burst", 16'h0100, 2, 4, 3, 1'b0);
    capture(16'h0203);
    chk("R2 restart drops drive", 32'(dq_oe), 0);
    expect_burst("R2 restarted burst", 16'h0203, 2, 4, 9, 1'b0);
    release_bus();
  endtask

  task automatic t_spare();
    cfg_write(3, 4);
    capture(16'hFEF0);
    chk("R12 no flag below spare", 32'(spare_err), 0);
    expect_burst("R12 wrap32 below spare", 16'hFEF0, 4, 3, 34, 1'b0);
    release_bus();
    capture(16'hFF1E);
    chk("R12 flag set", 32'(spare_err), 1);
    expect_burst("R12 fallback linear", 16'hFF1E, 4, 3, 40, 1'b1);
    release_bus();
    cfg_write(4, 3);
    capture(16'hFF05);
    expect_burst("R12 wrap16 in spare", 16'hFF05, 3, 4, 20, 1'b0);
    chk("R12 flag sticky", 32'(spare_err), 1);
    release_bus();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    tick();
    t_reset();
    t_latency();
    t_clamp();
    t_wrap();
    t_rollover_reserved();
    t_oe_pause();
    t_ce_end();
    t_restart();
    t_spare();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule